// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block connects a synchronous host request port to an asynchronous 256K x 16 extended-data-out DRAM. Each host request carries an 18-bit word address, a two-bit byte-enable and, for writes, sixteen bits of data. The controller puts the upper nine address bits on a shared nine-bit memory address bus as the row when RAS falls. It then puts the lower nine bits on the same bus as the column when CAS falls. There is one CAS strobe per byte lane, so a byte access strobes only the lanes it selects.

After an access the row stays open with RAS held low. A later request that falls in the same row runs as a page-mode cycle: it toggles only CAS, and any of the 512 columns of the open row can be reached this way. A request to another row, or a refresh request, closes the row and waits out the RAS precharge first. Read data is latched at the clock edge where CAS rises, because the memory keeps driving its outputs after CAS returns high. It is handed back with a one-cycle `rvalid` pulse.

Refresh itself belongs to an external scheduler. The scheduler raises `ref_req`, and the controller grants the memory pins once it is safe to do so. Every memory timing figure is a parameter counted in clock cycles, and the controller never shortens any of them.

Top module: `edo_page_ctrl`

## Requirements
- R1: For host address `req_addr`, the row is bits [17:9] and the column is bits [8:0]. `dram_addr` carries the row in the cycle RAS falls and the column in the cycle CAS falls.
- R2: `dram_cas_n[0]` strobes data bits 7:0 and is driven low only when `req_be[0]` is 1. `dram_cas_n[1]` strobes bits 15:8 and is driven low only when `req_be[1]` is 1. On a read, the bits of a lane that was not enabled come back as zero, and a write leaves the other lane of the memory word unchanged.
- R3: A request whose row equals the open row is served by a CAS cycle alone, with no new RAS fall.
- R4: A request to a different row is not accepted until RAS has risen and stayed high for at least `T_RP` cycles. RAS rises only while every CAS strobe is high.
- R5: CAS falls no sooner than `T_RCD` cycles after RAS falls. Each CAS low pulse lasts exactly `T_CAS` cycles. Consecutive CAS falls within one row are at least `T_PC` cycles apart. CAS is low only while RAS is low.
- R6: A read returns its data on `rdata` with a `rvalid` pulse of one cycle, one pulse per read, in request order. The data is latched at the edge where CAS rises.
- R7: A write drives `dram_we_n` low and `dram_dq_oe` high. A read drives `dram_oe_n` low. `dram_dq_oe` and a low `dram_oe_n` never coincide. `dram_dq_oe` rises only after `dram_oe_n` has been high for at least one full cycle.
- R8: A high `ref_req` closes any open row. After the precharge, `ref_gnt` rises and stays high with RAS and all CAS strobes high, and `req_ready` stays low, until `ref_req` falls. After the grant, the next access opens its row again.
- R9: While reset is held, RAS, both CAS strobes, WE and OE are high, and `dram_dq_oe`, `rvalid` and `ref_gnt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in [17:9], column in [8:0] |
| req_be | input | 2 | Byte enable, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rvalid | output | 1 | One-cycle read-return pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh scheduler wants the memory |
| ref_gnt | output | 1 | Memory pins idle and handed to the scheduler |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Per-lane column strobes, bit 0 = low byte |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Enable of the data-pin drivers |
| dram_dq_in | input | 16 | Data read from the memory pins |

## Verification
The bench targets three kinds of access. A page hit must add no RAS fall; a design that ignores the open row would show extra row cycles. A row miss must observe the full precharge; a design that opened the next row too soon would break the RAS-high count. A refresh in the middle of an open row must not leave that row marked open. The bench also probes the column edges 0x000 and 0x1FF and uses byte writes and byte reads per lane. A swapped row/column split or a wrong lane strobe would corrupt the read-back words. A write that follows a read in the same row checks the bus turnaround, which a design that drove data while OE was still low would violate. A request queued behind a refresh must stay blocked through the grant.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        S_IDLE,   // row closed, precharge satisfied
        S_ACT,    // RAS low, waiting row-to-column delay
        S_COL,    // column address and direction set up
        S_CASLO,  // CAS pulse in progress
        S_CASHI,  // CAS high, page cycle not yet complete
        S_OPEN,   // row open, ready for a hit
        S_PRE,    // RAS high, precharge in progress
        S_REF     // pins handed to the refresh scheduler
    } edo_state_e;

endpackage

// File: rtl/edo_phase_cnt.sv
module edo_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [ROW_W-1:0] cmp_i,
    output logic             hit_o
);
    logic             valid_d, valid_q;
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        valid_d = valid_q;
        row_d   = row_q;
        if (close_i) valid_d = 1'b0;
        if (open_i) begin
            valid_d = 1'b1;
            row_d   = row_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            row_q   <= '0;
        end else begin
            valid_q <= valid_d;
            row_q   <= row_d;
        end
    end

    assign hit_o = valid_q && (row_q == cmp_i);
endmodule

// File: rtl/edo_lane_map.sv
module edo_lane_map #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        be_i,
    output logic [LANES-1:0]        cas_n_o,
    output logic [LANES*LANE_W-1:0] mask_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cas_n_o[g]                  = ~be_i[g];
        assign mask_o[g*LANE_W +: LANE_W]  = {LANE_W{be_i[g]}};
    end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int COL_W  = 9,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 3,
    parameter int T_PC   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [ROW_W+COL_W-1:0]          req_addr,
    input  logic [LANES-1:0]                req_be,
    input  logic [LANES*LANE_W-1:0]         req_wdata,
    output logic                            rvalid,
    output logic [LANES*LANE_W-1:0]         rdata,
    input  logic                            ref_req,
    output logic                            ref_gnt,
    output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] dram_addr,
    output logic                            dram_ras_n,
    output logic [LANES-1:0]                dram_cas_n,
    output logic                            dram_we_n,
    output logic                            dram_oe_n,
    output logic [LANES*LANE_W-1:0]         dram_dq_out,
    output logic                            dram_dq_oe,
    input  logic [LANES*LANE_W-1:0]         dram_dq_in
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int DQ_W   = LANES * LANE_W;
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int TM_A   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TM_B   = (T_RP > T_PC) ? T_RP : T_PC;
    localparam int TMAX   = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int CW     = $clog2(TMAX + 1);

    typedef struct packed {
        edo_state_e       st;
        logic             ras_n;
        logic [LANES-1:0] cas_n;
        logic             we_n;
        logic             oe_n;
        logic             dq_oe;
        logic [MA_W-1:0]  ma;
        logic [DQ_W-1:0]  dq_out;
        logic             rvalid;
        logic [DQ_W-1:0]  rdata;
        logic             gnt;
        logic             wr;
        logic [LANES-1:0] be;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  wdata;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    assign req_row = req_addr[ADDR_W-1 -: ROW_W];
    assign req_col = req_addr[COL_W-1:0];

    // timing counters
    logic          ph_load, ph_zero, pc_load, pc_zero;
    logic [CW-1:0] ph_val, pc_val;

    edo_phase_cnt #(.W(CW)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .val(ph_val), .zero(ph_zero)
    );
    edo_phase_cnt #(.W(CW)) u_page (
        .clk(clk), .rst_n(rst_n), .load(pc_load), .val(pc_val), .zero(pc_zero)
    );

    // open-row tracking
    logic trk_open, trk_close, trk_hit;
    edo_row_track #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .open_i(trk_open), .close_i(trk_close),
        .row_i(req_row), .cmp_i(req_row), .hit_o(trk_hit)
    );

    // byte lanes
    logic [LANES-1:0] lane_cas_n;
    logic [DQ_W-1:0]  lane_mask;
    edo_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
        .be_i(s_q.be), .cas_n_o(lane_cas_n), .mask_o(lane_mask)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        ph_load    = 1'b0;
        ph_val     = '0;
        pc_load    = 1'b0;
        pc_val     = '0;
        trk_open   = 1'b0;
        trk_close  = 1'b0;
        req_ready  = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (ref_req) begin
                    s_d.st  = S_REF;
                    s_d.gnt = 1'b1;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        s_d.st    = S_ACT;
                        s_d.ras_n = 1'b0;
                        s_d.ma    = MA_W'(req_row);
                        s_d.wr    = req_write;
                        s_d.be    = req_be;
                        s_d.col   = req_col;
                        s_d.wdata = req_wdata;
                        ph_load   = 1'b1;
                        ph_val    = CW'(T_RCD - 1);
                        trk_open  = 1'b1;
                    end
                end
            end
            S_ACT: begin
                if (ph_zero) begin
                    s_d.st     = S_COL;
                    s_d.ma     = MA_W'(s_q.col);
                    s_d.we_n   = ~s_q.wr;
                    s_d.oe_n   = s_q.wr;
                    s_d.dq_oe  = s_q.wr;
                    s_d.dq_out = s_q.wdata;
                end
            end
            S_COL: begin
                s_d.st    = S_CASLO;
                s_d.cas_n = lane_cas_n;
                ph_load   = 1'b1;
                ph_val    = CW'(T_CAS - 1);
                pc_load   = 1'b1;
                pc_val    = CW'(T_PC - 1);
            end
            S_CASLO: begin
                if (ph_zero) begin
                    s_d.st    = S_CASHI;
                    s_d.cas_n = '1;
                    s_d.we_n  = 1'b1;
                    s_d.dq_oe = 1'b0;
                    if (!s_q.wr) begin
                        // EDO output still valid as CAS rises
                        s_d.rvalid = 1'b1;
                        s_d.rdata  = dram_dq_in & lane_mask;
                    end
                end
            end
            S_CASHI: begin
                if (pc_zero) begin
                    s_d.st   = S_OPEN;
                    s_d.oe_n = 1'b1;
                end
            end
            S_OPEN: begin
                if (ref_req || (req_valid && !trk_hit)) begin
                    s_d.st    = S_PRE;
                    s_d.ras_n = 1'b1;
                    ph_load   = 1'b1;
                    ph_val    = CW'(T_RP - 1);
                    trk_close = 1'b1;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        s_d.st     = S_COL;
                        s_d.wr     = req_write;
                        s_d.be     = req_be;
                        s_d.col    = req_col;
                        s_d.wdata  = req_wdata;
                        s_d.ma     = MA_W'(req_col);
                        s_d.we_n   = ~req_write;
                        s_d.oe_n   = req_write;
                        s_d.dq_oe  = req_write;
                        s_d.dq_out = req_wdata;
                    end
                end
            end
            S_PRE: begin
                if (ph_zero) s_d.st = S_IDLE;
            end
            S_REF: begin
                if (!ref_req) begin
                    s_d.st  = S_PRE;
                    s_d.gnt = 1'b0;
                    ph_load = 1'b1;
                    ph_val  = CW'(T_RP - 1);
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ras_n <= 1'b1;
            s_q.cas_n <= '1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dram_addr   = s_q.ma;
    assign dram_ras_n  = s_q.ras_n;
    assign dram_cas_n  = s_q.cas_n;
    assign dram_we_n   = s_q.we_n;
    assign dram_oe_n   = s_q.oe_n;
    assign dram_dq_out = s_q.dq_out;
    assign dram_dq_oe  = s_q.dq_oe;
    assign rvalid      = s_q.rvalid;
    assign rdata       = s_q.rdata;
    assign ref_gnt     = s_q.gnt;

    // ---------------- assertions ----------------
    initial begin
        assert (T_RCD >= 1 && T_CAS >= 1 && T_RP >= 1);
        assert (T_PC > T_CAS);
    end

    logic [7:0] ras_hi_cnt, cas_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_hi_cnt <= 8'hFF;
            cas_lo_cnt <= '0;
        end else begin
            if (!dram_ras_n)               ras_hi_cnt <= '0;
            else if (ras_hi_cnt != 8'hFF)  ras_hi_cnt <= ras_hi_cnt + 8'd1;
            if (dram_cas_n == '1)          cas_lo_cnt <= '0;
            else if (cas_lo_cnt != 8'hFF)  cas_lo_cnt <= cas_lo_cnt + 8'd1;
        end
    end

    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ras_hi_cnt >= 8'(T_RP));

    assert_row_close_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> ($past(dram_cas_n) == '1) && (dram_cas_n == '1));

    assert_cas_within_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cas_n != '1) |-> !dram_ras_n);

    assert_cas_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dram_cas_n == '1) && ($past(dram_cas_n) != '1)) |-> cas_lo_cnt == 8'(T_CAS));

    assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_dq_oe && !dram_oe_n));

    assert_bus_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_dq_oe) |-> dram_oe_n && $past(dram_oe_n));

    assert_grant_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> dram_ras_n && (dram_cas_n == '1) && !req_ready);
endmodule

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RP  = 3;
    localparam int T_PC  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rvalid;
    logic [15:0] rdata;
    logic        ref_req = 1'b0;
    logic        ref_gnt;
    logic [8:0]  dram_addr;
    logic        dram_ras_n;
    logic [1:0]  dram_cas_n;
    logic        dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out, dram_dq_in;

    always #2.5 clk = ~clk;

    edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_PC(T_PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rvalid(rvalid), .rdata(rdata), .ref_req(ref_req),
        .ref_gnt(ref_gnt), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // ---------------- memory model (clock-sampled) ----------------
    logic [15:0] mem [int];
    logic [15:0] ref_mem [int];
    logic [15:0] rd_word = '0;
    int          pend_a[$];
    logic [1:0]  pend_b[$];
    logic [15:0] exp_q[$];
    int          ras_falls = 0;
    int          reads_out = 0;
    logic        p_ras = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
    logic [1:0]  p_cas = 2'b11;
    logic [8:0]  cur_row = '0;
    int          ras_hi = 1000, ras_lo = 0, since_cas = 1000, cas_lo = 0;

    assign dram_dq_in = dram_oe_n ? 16'h0000 : rd_word;

    always @(negedge clk) begin
        if (rst_n) begin
            // RAS edge
            if (p_ras && !dram_ras_n) begin
                ras_falls++;
                chk(ras_hi >= T_RP, "R4 precharge before RAS fall", ras_hi, T_RP);
                cur_row = dram_addr;
                if (pend_a.size() > 0)
                    chk(dram_addr == 9'(pend_a[0] >> 9), "R1 row on address bus",
                        dram_addr, pend_a[0] >> 9);
                ras_lo = 0;
                since_cas = 1000;
            end else if (!dram_ras_n) ras_lo++;
            if (dram_ras_n) ras_hi = p_ras ? ras_hi + 1 : 1;
            since_cas++;
            // CAS fall
            if (p_cas == 2'b11 && dram_cas_n != 2'b11) begin
                int idx;
                chk(ras_lo >= T_RCD, "R5 RAS to CAS delay", ras_lo, T_RCD);
                chk(since_cas >= T_PC, "R5 page cycle", since_cas, T_PC);
                idx = int'({cur_row, dram_addr});
                if (pend_a.size() > 0) begin
                    chk(dram_addr == 9'(pend_a[0]), "R1 column on address bus",
                        dram_addr, 9'(pend_a[0]));
                    chk(dram_cas_n == ~pend_b[0], "R2 lane strobes", dram_cas_n, ~pend_b[0]);
                    void'(pend_a.pop_front());
                    void'(pend_b.pop_front());
                end
                if (!dram_we_n) begin
                    logic [15:0] w;
                    chk(dram_dq_oe, "R7 write drives data bus", dram_dq_oe, 1);
                    w = mem.exists(idx) ? mem[idx] : 16'h0;
                    if (!dram_cas_n[0]) w[7:0]  = dram_dq_out[7:0];
                    if (!dram_cas_n[1]) w[15:8] = dram_dq_out[15:8];
                    mem[idx] = w;
                end else begin
                    rd_word = mem.exists(idx) ? mem[idx] : 16'h0;
                end
                since_cas = 0;
                cas_lo = 0;
            end
            if (dram_cas_n != 2'b11) cas_lo++;
            if (p_cas != 2'b11 && dram_cas_n == 2'b11)
                chk(cas_lo == T_CAS, "R5 CAS pulse width", cas_lo, T_CAS);
            // bus direction
            if (dram_dq_oe && !dram_oe_n)
                chk(1'b0, "R7 data bus contention", 1, 0);
            if (dram_dq_oe && !p_dqoe)
                chk(dram_oe_n && p_oe, "R7 turnaround before write", {p_oe, dram_oe_n}, 2'b11);
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_oe = dram_oe_n; p_dqoe = dram_dq_oe;
        end
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected rvalid", rdata, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rdata === e, "R6/R2 read data", rdata, e);
                reads_out--;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic do_req(input bit wr, input logic [17:0] a, input logic [1:0] be,
                          input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        pend_a.push_back(int'(a));
        pend_b.push_back(be);
        if (wr) begin
            logic [15:0] w;
            w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
            if (be[0]) w[7:0]  = wd[7:0];
            if (be[1]) w[15:8] = wd[15:8];
            ref_mem[int'(a)] = w;
        end else begin
            logic [15:0] r;
            r = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
            exp_q.push_back(r & {{8{be[1]}}, {8{be[0]}}});
            reads_out++;
        end
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (exp_q.size() != 0 || pend_a.size() != 0); i++)
            @(negedge clk);
        repeat (T_PC + 2) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    endtask

    task automatic do_refresh(input int hold);
        @(negedge clk);
        ref_req = 1'b1;
        while (!ref_gnt) @(negedge clk);
        for (int i = 0; i < hold; i++) begin
            chk(dram_ras_n && dram_cas_n == 2'b11, "R8 pins idle during grant",
                {dram_ras_n, dram_cas_n}, 3'b111);
            if (req_valid) chk(!req_ready, "R8 request held off in grant", req_ready, 0);
            @(negedge clk);
        end
        ref_req = 1'b0;
        @(negedge clk);
        chk(!ref_gnt, "R8 grant released", ref_gnt, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && dram_oe_n,
            "R9 strobes high in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1F);
        chk(!dram_dq_oe && !rvalid && !ref_gnt, "R9 outputs low in reset",
            {dram_dq_oe, rvalid, ref_gnt}, 0);
        rst_n = 1'b1;

        // page hits in row 0
        base = ras_falls;
        do_req(1, 18'h00005, 2'b11, 16'h1234);
        do_req(1, 18'h00006, 2'b11, 16'h5678);
        do_req(0, 18'h00005, 2'b11, 16'h0);
        do_req(0, 18'h00006, 2'b11, 16'h0);
        drain();
        chk(ras_falls - base == 1, "R3 page hits use one RAS", ras_falls - base, 1);

        // row miss
        base = ras_falls;
        do_req(1, 18'h3FE05, 2'b11, 16'hBEEF);
        do_req(0, 18'h3FE05, 2'b11, 16'h0);
        do_req(0, 18'h00005, 2'b11, 16'h0);
        drain();
        chk(ras_falls - base == 2, "R4 row misses reopen", ras_falls - base, 2);

        // byte lanes
        do_req(1, 18'h00005, 2'b10, 16'hABCD);
        do_req(0, 18'h00005, 2'b11, 16'h0);
        do_req(0, 18'h00005, 2'b01, 16'h0);
        do_req(1, 18'h00006, 2'b01, 16'h0099);
        do_req(0, 18'h00006, 2'b10, 16'h0);
        do_req(0, 18'h00006, 2'b11, 16'h0);
        drain();

        // column boundaries in one row, swapped-looking addresses
        do_req(1, {9'h155, 9'h1FF}, 2'b11, 16'hA1A1);
        do_req(1, {9'h155, 9'h000}, 2'b11, 16'hB2B2);
        do_req(1, {9'h0AA, 9'h155}, 2'b11, 16'hC3C3);
        do_req(0, {9'h155, 9'h1FF}, 2'b11, 16'h0);
        do_req(0, {9'h155, 9'h000}, 2'b11, 16'h0);
        do_req(0, {9'h0AA, 9'h155}, 2'b11, 16'h0);
        drain();

        // refresh with the row open, then same row again
        do_req(0, {9'h155, 9'h000}, 2'b11, 16'h0);
        drain();
        base = ras_falls;
        do_refresh(3);
        do_req(0, {9'h155, 9'h1FF}, 2'b11, 16'h0);
        drain();
        chk(ras_falls - base == 1, "R8 row reopened after refresh", ras_falls - base, 1);

        // request pending behind a refresh
        base = ras_falls;
        fork
            do_refresh(4);
            begin
                @(negedge clk);
                do_req(0, {9'h155, 9'h000}, 2'b11, 16'h0);
            end
        join
        drain();
        chk(ras_falls - base == 1, "R8 queued request after grant", ras_falls - base, 1);

        // long page burst with write-after-read turnarounds
        base = ras_falls;
        for (int k = 0; k < 8; k++) begin
            do_req(0, {9'h033, 9'(k * 37)}, 2'b11, 16'h0);
            do_req(1, {9'h033, 9'(k * 37)}, 2'b11, 16'(16'h1111 * (k + 1)));
        end
        for (int k = 0; k < 8; k++)
            do_req(0, {9'h033, 9'(k * 37)}, 2'b11, 16'h0);
        drain();
        chk(ras_falls - base == 1, "R3 burst stays in one row", ras_falls - base, 1);

        finish_run();
    end
endmodule